// File: doc/BRIEF.md
# Direct Segment Address Translator

This block translates virtual addresses for a single core or hardware thread. It holds one contiguous mapping window, given by a base, a limit and an offset, all page aligned. An address inside the window is translated by a single add: the physical address is the virtual address plus the offset. No TLB lookup is made for it, so it can never miss. Any other address is forwarded on a lookup port to the conventional paging path, and the answer from that path is returned without change.

A single permission bit covers the whole window. A write to a read-only window returns a protection fault code instead of an address. Every response carries a flag that shows whether the segment or paging produced it. Up to `DEPTH` translations may be in flight. Responses always leave in acceptance order, so a window hit that is accepted behind a pending paging lookup waits for that lookup to finish. A configuration write is held off until nothing is in flight, and new requests are stalled while the write is pending.

Top module: `dseg_xlate`

## Requirements
- R1: After reset the window is empty: `reqReady` is 1 while no configuration write is pending, `respValid`, `tlbReqValid` and `cfgWrReady` are 0, and the first request goes to paging.
- R2: An address V is in the window exactly when base <= V < limit. The lower bound is inclusive and the upper bound is exclusive, both compared on the full 48-bit address.
- R3: For an in-window request no lookup is issued (`tlbReqValid` stays 0). The response carries paddr = (V + offset) mod 2^48, fault 0 and `respFromSeg` = 1.
- R4: An in-window request accepted while no translation is in flight has `respValid` high in the cycle after acceptance.
- R5: An out-of-window request is issued on the lookup port with the same address and write flag. Its response carries the lookup port's paddr and fault unchanged, with `respFromSeg` = 0.
- R6: When limit <= base (including base == limit), every address goes to paging.
- R7: Writes to base, limit and offset ignore data bits [11:0]. Register select `cfgSel` encodes 0 = base, 1 = limit, 2 = offset, 3 = permission.
- R8: A configuration write completes (`cfgWrReady` = 1) only when no translation is in flight. While `cfgWrEn` is high, `reqReady` is 0 and no request is accepted.
- R9: The permission register takes data bit 0 (1 = writes allowed, reset value 1). An in-window write while writes are not allowed returns fault code 3, paddr 0 and `respFromSeg` = 1. In-window reads are unaffected.
- R10: Responses are returned in acceptance order, whichever path produced each one.
- R11: While `respValid` is high and `respReady` is low, the response stays valid and its fields do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Translation request present |
| reqReady | output | 1 | Request accepted this cycle when high with reqValid |
| reqVaddr | input | 48 | Virtual address |
| reqWrite | input | 1 | Access type, 1 = write |
| respValid | output | 1 | Response present |
| respReady | input | 1 | Consumer takes the response |
| respPaddr | output | 48 | Physical address |
| respFault | output | 2 | Fault code, 0 = none |
| respFromSeg | output | 1 | 1 = translated by the segment, 0 = by paging |
| tlbReqValid | output | 1 | Lookup request to paging |
| tlbReqReady | input | 1 | Paging path takes the lookup |
| tlbReqVaddr | output | 48 | Lookup address |
| tlbReqWrite | output | 1 | Lookup access type |
| tlbRespValid | input | 1 | Lookup result, in lookup order |
| tlbRespPaddr | input | 48 | Lookup physical address |
| tlbRespFault | input | 2 | Lookup fault code |
| cfgWrEn | input | 1 | Configuration write pending |
| cfgWrReady | output | 1 | Configuration write applied this cycle |
| cfgSel | input | 2 | Register select |
| cfgWrData | input | 48 | Write data |

## Verification
The hardest situation to reach from the ports is a configuration write that is waiting on in-flight work: it has to be held back while slow lookups and window hits queued behind them drain in order. The bench gets there by giving its paging model a long latency, issuing a miss followed by a hit, and then raising the write strobe at once. It watches the stall and the completion cycle. Ordering is stressed by sweeping every base/limit pair on a small page grid, with varied lookup latencies and a throttled response consumer.

// File: rtl/dseg_pkg.sv
package dseg_pkg;

  localparam int FLT_W = 2;

  localparam logic [FLT_W-1:0] FLT_NONE = 2'd0;
  localparam logic [FLT_W-1:0] FLT_PROT = 2'd3;

  // register select encoding
  typedef enum logic [1:0] {
    CFG_BASE   = 2'd0,
    CFG_LIMIT  = 2'd1,
    CFG_OFFSET = 2'd2,
    CFG_PERM   = 2'd3
  } cfgSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic alloc;     // a request is accepted into the in-order buffer
    logic allocSeg;  // the accepted request hit the window
    logic tlbFill;   // a paging result lands in its slot
    logic cfgWrite;  // configuration register update
  } ctrlStrb_t;

endpackage

// File: rtl/dseg_ctrl.sv
module dseg_ctrl
  import dseg_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             segHit,
  input  logic             tlbReqReady,
  input  logic             tlbRespValid,
  input  logic             respReady,
  input  logic             cfgWrEn,
  output logic             reqReady,
  output logic             tlbReqValid,
  output logic             respValid,
  output logic             cfgWrReady,
  output ctrlStrb_t        strb,
  output logic [PTR_W-1:0] allocIdx,
  output logic [PTR_W-1:0] fillIdx,
  output logic [PTR_W-1:0] headIdx
);

  localparam int CNT_W = PTR_W + 1;

  logic [DEPTH-1:0] slotValid;
  logic [DEPTH-1:0] slotDone;
  logic [PTR_W-1:0] headPtr;
  logic [PTR_W-1:0] tailPtr;
  logic [CNT_W-1:0] count;
  logic             isEmpty;
  logic             isFull;
  logic             canTake;
  logic             fillFound;
  logic             popNow;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign isEmpty  = (count == '0);
  assign isFull   = (count == CNT_W'(DEPTH));
  assign canTake  = !cfgWrEn && !isFull;

  assign reqReady    = canTake && (segHit || tlbReqReady);
  assign tlbReqValid = reqValid && canTake && !segHit;
  assign cfgWrReady  = cfgWrEn && isEmpty;

  assign respValid = slotValid[headPtr] && slotDone[headPtr];
  assign popNow    = respValid && respReady;

  // oldest pending slot: paging results come back in lookup order
  always_comb begin
    fillFound = 1'b0;
    fillIdx   = '0;
    for (int i = 0; i < DEPTH; i++) begin
      int k;
      k = (int'(headPtr) + i) % DEPTH;
      if (!fillFound && slotValid[k] && !slotDone[k]) begin
        fillFound = 1'b1;
        fillIdx   = PTR_W'(k);
      end
    end
  end

  always_comb begin
    strb          = '0;
    strb.alloc    = reqValid && reqReady;
    strb.allocSeg = reqValid && reqReady && segHit;
    strb.tlbFill  = tlbRespValid && fillFound;
    strb.cfgWrite = cfgWrReady;
  end

  assign allocIdx = tailPtr;
  assign headIdx  = headPtr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotValid <= '0;
      slotDone  <= '0;
      headPtr   <= '0;
      tailPtr   <= '0;
      count     <= '0;
    end else begin
      if (strb.alloc) begin
        slotValid[tailPtr] <= 1'b1;
        slotDone[tailPtr]  <= segHit;
        tailPtr            <= bump(tailPtr);
      end
      if (strb.tlbFill) begin
        slotDone[fillIdx] <= 1'b1;
      end
      if (popNow) begin
        slotValid[headPtr] <= 1'b0;
        slotDone[headPtr]  <= 1'b0;
        headPtr            <= bump(headPtr);
      end
      case ({strb.alloc, popNow})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end

  // R4: a window hit on an idle buffer answers in the next cycle
  p_hit_latency_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.allocSeg && isEmpty) |=> respValid);

  // R11: a response that is not taken stays up
  p_resp_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && !respReady) |=> respValid);

  // R8: occupancy never grows while a configuration write waits
  p_stall_r8: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && $past(cfgWrEn)) |-> (count <= $past(count)));

endmodule

// File: rtl/dseg_datapath.sv
module dseg_datapath
  import dseg_pkg::*;
#(
  parameter int ADDR_W = 48,
  parameter int PAGE_W = 12,
  parameter int DEPTH  = 4,
  parameter int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrb_t         strb,
  input  logic [PTR_W-1:0]  allocIdx,
  input  logic [PTR_W-1:0]  fillIdx,
  input  logic [PTR_W-1:0]  headIdx,
  input  logic [ADDR_W-1:0] reqVaddr,
  input  logic              reqWrite,
  input  logic [1:0]        cfgSel,
  input  logic [ADDR_W-1:0] cfgWrData,
  input  logic [ADDR_W-1:0] tlbRespPaddr,
  input  logic [FLT_W-1:0]  tlbRespFault,
  output logic              segHit,
  output logic [ADDR_W-1:0] respPaddr,
  output logic [FLT_W-1:0]  respFault,
  output logic              respFromSeg
);

  localparam logic [ADDR_W-1:0] PAGE_MASK =
    {{(ADDR_W - PAGE_W){1'b1}}, {PAGE_W{1'b0}}};

  logic [ADDR_W-1:0] baseReg;
  logic [ADDR_W-1:0] limitReg;
  logic [ADDR_W-1:0] offReg;
  logic              permWr;

  logic [ADDR_W-1:0] segPaddr;
  logic              segDeny;

  logic [ADDR_W-1:0] paArr  [DEPTH];
  logic [FLT_W-1:0]  fltArr [DEPTH];
  logic [DEPTH-1:0]  segArr;

  // segment registers, page aligned
  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseReg  <= '0;
      limitReg <= '0;
      offReg   <= '0;
      permWr   <= 1'b1;
    end else if (strb.cfgWrite) begin
      case (cfgSel_e'(cfgSel))
        CFG_BASE:   baseReg  <= cfgWrData & PAGE_MASK;
        CFG_LIMIT:  limitReg <= cfgWrData & PAGE_MASK;
        CFG_OFFSET: offReg   <= cfgWrData & PAGE_MASK;
        default:    permWr   <= cfgWrData[0];
      endcase
    end
  end

  // range compare, add, permission
  assign segHit   = (reqVaddr >= baseReg) && (reqVaddr < limitReg);
  assign segPaddr = reqVaddr + offReg;
  assign segDeny  = reqWrite && !permWr;

  // result slots
  always_ff @(posedge clk) begin
    if (strb.alloc) begin
      segArr[allocIdx] <= strb.allocSeg;
      if (strb.allocSeg) begin
        paArr[allocIdx]  <= segDeny ? '0 : segPaddr;
        fltArr[allocIdx] <= segDeny ? FLT_PROT : FLT_NONE;
      end
    end
    if (strb.tlbFill) begin
      paArr[fillIdx]  <= tlbRespPaddr;
      fltArr[fillIdx] <= tlbRespFault;
    end
  end

  assign respPaddr   = paArr[headIdx];
  assign respFault   = fltArr[headIdx];
  assign respFromSeg = segArr[headIdx];

  // R6: an empty or inverted window matches nothing
  p_empty_seg_r6: assert property (@(posedge clk) disable iff (!rstN)
    (limitReg <= baseReg) |-> !segHit);

endmodule

// File: rtl/dseg_xlate.sv
module dseg_xlate
  import dseg_pkg::*;
#(
  parameter int ADDR_W = 48,
  parameter int PAGE_W = 12,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqVaddr,
  input  logic              reqWrite,
  output logic              respValid,
  input  logic              respReady,
  output logic [ADDR_W-1:0] respPaddr,
  output logic [1:0]        respFault,
  output logic              respFromSeg,
  output logic              tlbReqValid,
  input  logic              tlbReqReady,
  output logic [ADDR_W-1:0] tlbReqVaddr,
  output logic              tlbReqWrite,
  input  logic              tlbRespValid,
  input  logic [ADDR_W-1:0] tlbRespPaddr,
  input  logic [1:0]        tlbRespFault,
  input  logic              cfgWrEn,
  output logic              cfgWrReady,
  input  logic [1:0]        cfgSel,
  input  logic [ADDR_W-1:0] cfgWrData
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  ctrlStrb_t        strb;
  logic             segHit;
  logic [PTR_W-1:0] allocIdx;
  logic [PTR_W-1:0] fillIdx;
  logic [PTR_W-1:0] headIdx;

  assign tlbReqVaddr = reqVaddr;
  assign tlbReqWrite = reqWrite;

  dseg_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .reqValid     (reqValid),
    .segHit       (segHit),
    .tlbReqReady  (tlbReqReady),
    .tlbRespValid (tlbRespValid),
    .respReady    (respReady),
    .cfgWrEn      (cfgWrEn),
    .reqReady     (reqReady),
    .tlbReqValid  (tlbReqValid),
    .respValid    (respValid),
    .cfgWrReady   (cfgWrReady),
    .strb         (strb),
    .allocIdx     (allocIdx),
    .fillIdx      (fillIdx),
    .headIdx      (headIdx)
  );

  dseg_datapath #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DEPTH(DEPTH), .PTR_W(PTR_W)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .allocIdx     (allocIdx),
    .fillIdx      (fillIdx),
    .headIdx      (headIdx),
    .reqVaddr     (reqVaddr),
    .reqWrite     (reqWrite),
    .cfgSel       (cfgSel),
    .cfgWrData    (cfgWrData),
    .tlbRespPaddr (tlbRespPaddr),
    .tlbRespFault (tlbRespFault),
    .segHit       (segHit),
    .respPaddr    (respPaddr),
    .respFault    (respFault),
    .respFromSeg  (respFromSeg)
  );

  // R3: a window hit never reaches the paging path
  p_bypass_r3: assert property (@(posedge clk) disable iff (!rstN)
    tlbReqValid |-> !segHit);

  // R9: a protection fault from the segment carries no address
  p_prot_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && respFromSeg && (respFault == FLT_PROT)) |-> (respPaddr == '0));

endmodule

// File: tb/dseg_xlate_test.sv
module dseg_xlate_test;

  localparam logic [47:0] MASK = {{36{1'b1}}, 12'h000};

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [47:0] reqVaddr = '0;
  logic        reqWrite = 1'b0;
  logic        respValid;
  logic        respReady;
  logic [47:0] respPaddr;
  logic [1:0]  respFault;
  logic        respFromSeg;
  logic        tlbReqValid;
  logic        tlbReqReady = 1'b1;
  logic [47:0] tlbReqVaddr;
  logic        tlbReqWrite;
  logic        tlbRespValid = 1'b0;
  logic [47:0] tlbRespPaddr = '0;
  logic [1:0]  tlbRespFault = '0;
  logic        cfgWrEn = 1'b0;
  logic        cfgWrReady;
  logic [1:0]  cfgSel = '0;
  logic [47:0] cfgWrData = '0;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int tlbLat = 1;
  bit stallMode = 1'b0;
  bit finished = 1'b0;

  // shadow of the segment registers, from the requirements
  logic [47:0] sBase = '0, sLimit = '0, sOff = '0;
  logic        sPermW = 1'b1;

  // expected responses in order
  logic [47:0] expPa  [64];
  logic [1:0]  expFlt [64];
  logic        expSeg [64];
  logic        expEmpty [64];
  int expHead = 0, expN = 0;

  // paging model queue
  logic [47:0] tqA [16];
  int          tqAge [16];
  int          tqN = 0;

  bit          latPend = 1'b0;
  bit          holdPend = 1'b0;
  logic [47:0] holdPa;
  logic        holdSeg;

  dseg_xlate uut (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqReady(reqReady), .reqVaddr(reqVaddr), .reqWrite(reqWrite),
    .respValid(respValid), .respReady(respReady), .respPaddr(respPaddr),
    .respFault(respFault), .respFromSeg(respFromSeg),
    .tlbReqValid(tlbReqValid), .tlbReqReady(tlbReqReady), .tlbReqVaddr(tlbReqVaddr),
    .tlbReqWrite(tlbReqWrite), .tlbRespValid(tlbRespValid), .tlbRespPaddr(tlbRespPaddr),
    .tlbRespFault(tlbRespFault),
    .cfgWrEn(cfgWrEn), .cfgWrReady(cfgWrReady), .cfgSel(cfgSel), .cfgWrData(cfgWrData)
  );

  always #10 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;
  assign respReady = !stallMode || (cyc % 3 != 0);

  function automatic logic [47:0] tlbPa(input logic [47:0] v);
    return {v[47:12] ^ 36'h0000005A5, v[11:0]};
  endfunction

  function automatic logic [1:0] tlbFlt(input logic [47:0] v);
    return v[47] ? 2'd2 : 2'd0;
  endfunction

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  // paging path model: in order, fixed latency
  always @(negedge clk) begin
    if (!rstN) begin
      tqN = 0;
      tlbRespValid = 1'b0;
    end else begin
      if (tlbRespValid) begin
        for (int i = 0; i < 15; i++) begin
          tqA[i] = tqA[i+1];
          tqAge[i] = tqAge[i+1];
        end
        tqN--;
      end
      for (int i = 0; i < tqN; i++) tqAge[i]++;
      if (tlbReqValid && tlbReqReady && tqN < 16) begin
        tqA[tqN] = tlbReqVaddr;
        tqAge[tqN] = 0;
        tqN++;
      end
      if (tqN > 0 && tqAge[0] >= tlbLat) begin
        tlbRespValid = 1'b1;
        tlbRespPaddr = tlbPa(tqA[0]);
        tlbRespFault = tlbFlt(tqA[0]);
      end else begin
        tlbRespValid = 1'b0;
      end
    end
  end

  // monitor and scoreboard
  always @(negedge clk) begin
    if (rstN) begin
      if (holdPend) begin
        checks++;
        if (!(respValid && respPaddr == holdPa && respFromSeg == holdSeg)) begin
          fails++;
          $display("FAIL R11 hold: valid=%0b paddr=%h expected valid=1 paddr=%h", respValid, respPaddr, holdPa);
        end
      end
      holdPend = respValid && !respReady;
      holdPa = respPaddr;
      holdSeg = respFromSeg;

      if (latPend) begin
        checks++;
        if (!(respValid && respFromSeg)) begin
          fails++;
          $display("FAIL R4 latency: valid=%0b seg=%0b expected valid=1 seg=1", respValid, respFromSeg);
        end
        latPend = 1'b0;
      end

      if (respValid && respReady) begin
        checks++;
        if (expN == 0) begin
          fails++;
          $display("FAIL R10 unexpected response: paddr=%h expected none", respPaddr);
        end else begin
          if (respPaddr !== expPa[expHead] || respFault !== expFlt[expHead] ||
              respFromSeg !== expSeg[expHead]) begin
            fails++;
            if (respFromSeg !== expSeg[expHead])
              $display("FAIL R10 order: paddr=%h fault=%0d seg=%0b expected paddr=%h fault=%0d seg=%0b",
                       respPaddr, respFault, respFromSeg, expPa[expHead], expFlt[expHead], expSeg[expHead]);
            else if (expSeg[expHead] && expFlt[expHead] != 0)
              $display("FAIL R9 protection: paddr=%h fault=%0d expected paddr=%h fault=%0d",
                       respPaddr, respFault, expPa[expHead], expFlt[expHead]);
            else if (expSeg[expHead])
              $display("FAIL R2 R3 segment: paddr=%h fault=%0d expected paddr=%h fault=%0d",
                       respPaddr, respFault, expPa[expHead], expFlt[expHead]);
            else if (expEmpty[expHead])
              $display("FAIL R6 paging: paddr=%h fault=%0d expected paddr=%h fault=%0d",
                       respPaddr, respFault, expPa[expHead], expFlt[expHead]);
            else
              $display("FAIL R2 R5 paging: paddr=%h fault=%0d expected paddr=%h fault=%0d",
                       respPaddr, respFault, expPa[expHead], expFlt[expHead]);
          end
          expHead = (expHead + 1) % 64;
          expN--;
        end
      end

      if (reqValid && reqReady) begin
        logic hit;
        int t;
        hit = (reqVaddr >= sBase) && (reqVaddr < sLimit);
        t = (expHead + expN) % 64;
        expSeg[t] = hit;
        expEmpty[t] = (sLimit <= sBase);
        if (hit) begin
          if (reqWrite && !sPermW) begin
            expPa[t] = '0;
            expFlt[t] = 2'd3;
          end else begin
            expPa[t] = reqVaddr + sOff;
            expFlt[t] = 2'd0;
          end
          if (expN == 0) latPend = 1'b1;
        end else begin
          expPa[t] = tlbPa(reqVaddr);
          expFlt[t] = tlbFlt(reqVaddr);
        end
        expN++;
        checks++;
        if (hit && tlbReqValid) begin
          fails++;
          $display("FAIL R3 lookup issued for window hit: tlbReqValid=1 expected 0");
        end else if (!hit && !(tlbReqValid && tlbReqVaddr == reqVaddr && tlbReqWrite == reqWrite)) begin
          fails++;
          $display("FAIL R5 lookup: valid=%0b addr=%h expected valid=1 addr=%h",
                   tlbReqValid, tlbReqVaddr, reqVaddr);
        end
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    if (cyc > 150000 && !finished) begin
      fails++;
      $display("FAIL watchdog: run did not end, cycles=%0d expected < 150000", cyc);
      summary();
      $finish;
    end
  end

  task automatic doReq(input logic [47:0] v, input logic w);
    reqVaddr = v;
    reqWrite = w;
    reqValid = 1'b1;
    forever begin
      @(negedge clk);
      if (reqReady) break;
    end
    @(posedge clk);
    #1 reqValid = 1'b0;
  endtask

  // R7: low bits of base, limit and offset data are dropped
  task automatic writeCfg(input logic [1:0] sel, input logic [47:0] d);
    cfgSel = sel;
    cfgWrData = d;
    cfgWrEn = 1'b1;
    forever begin
      @(negedge clk);
      if (cfgWrReady) break;
    end
    @(posedge clk);
    #1 cfgWrEn = 1'b0;
    case (sel)
      2'd0: sBase = d & MASK;
      2'd1: sLimit = d & MASK;
      2'd2: sOff = d & MASK;
      default: sPermW = d[0];
    endcase
  endtask

  task automatic drain();
    forever begin
      @(negedge clk);
      if (expN == 0 && !respValid) break;
    end
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(reqReady == 1'b1, "R1 reqReady after reset", int'(reqReady), 1);
    chk(respValid == 1'b0, "R1 respValid after reset", int'(respValid), 0);
    chk(tlbReqValid == 1'b0, "R1 tlbReqValid after reset", int'(tlbReqValid), 0);
    chk(cfgWrReady == 1'b0, "R1 cfgWrReady after reset", int'(cfgWrReady), 0);
    @(posedge clk);
    #1;
    doReq(48'h0000_0000_0123, 1'b0);  // R1: empty window, goes to paging
    drain();

    // sweep base/limit pairs on a small page grid (R2 R3 R5 R6 R9 R10 R11)
    for (int b = 0; b < 6; b++) begin
      for (int l = 0; l < 6; l++) begin
        tlbLat = 1 + (b + l) % 4;
        stallMode = (b % 2 == 1);
        writeCfg(2'd0, {36'h000000100 + 36'(b), 12'hABC});
        writeCfg(2'd1, {36'h000000100 + 36'(l), 12'h5F1});
        writeCfg(2'd2, {36'hFFFFFFF00 + 36'(b * 16 + l), 12'hFFF});
        writeCfg(2'd3, {47'h7FFF_FFFF_FFFE, 1'((b + l) % 2)});
        for (int p = 0; p < 8; p++) begin
          for (int w = 0; w < 2; w++) begin
            doReq({36'h0000000FF + 36'(p), 12'((p * 37 + b * 5 + w) & 12'hFFF)}, 1'(w));
          end
        end
        drain();
      end
    end
    stallMode = 1'b0;

    // R2 R3: top of the address space, add wraps modulo 2^48
    writeCfg(2'd3, 48'h1);
    writeCfg(2'd0, 48'hFFFF_FFFF_E000);
    writeCfg(2'd1, 48'hFFFF_FFFF_F000);
    writeCfg(2'd2, 48'h0000_0000_2000);
    doReq(48'hFFFF_FFFF_E7FF, 1'b1);  // inside, wraps to 0x7FF
    doReq(48'hFFFF_FFFF_F000, 1'b0);  // limit itself: paging, bit47 fault from model
    doReq(48'hFFFF_FFFF_DFFF, 1'b0);  // just below base
    drain();

    // R10: hit queued behind a slow lookup must wait
    tlbLat = 6;
    writeCfg(2'd0, 48'h0000_0010_0000);
    writeCfg(2'd1, 48'h0000_0020_0000);
    writeCfg(2'd2, 48'h0000_1000_0000);
    doReq(48'h0000_0000_5000, 1'b0);
    doReq(48'h0000_0010_0040, 1'b1);
    doReq(48'h0000_0011_0000, 1'b0);
    doReq(48'h0000_0000_6000, 1'b1);
    drain();

    // R8: configuration write waits for in-flight work, requests stall
    tlbLat = 8;
    doReq(48'h0000_0000_7000, 1'b0);
    doReq(48'h0000_0010_1000, 1'b0);
    cfgSel = 2'd2;
    cfgWrData = 48'h0000_2000_0123;
    cfgWrEn = 1'b1;
    reqVaddr = 48'h0000_0010_2000;
    reqWrite = 1'b0;
    reqValid = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(cfgWrReady == 1'b0, "R8 write held while busy", int'(cfgWrReady), 0);
      chk(reqReady == 1'b0, "R8 request stalled during write", int'(reqReady), 0);
    end
    forever begin
      @(negedge clk);
      if (cfgWrReady) break;
      chk(reqReady == 1'b0, "R8 request stalled during write", int'(reqReady), 0);
    end
    chk(expN == 0, "R8 nothing in flight at write", expN, 0);
    @(posedge clk);
    #1 cfgWrEn = 1'b0;
    sOff = 48'h0000_2000_0000;
    doReq(48'h0000_0010_2000, 1'b0);   // uses the new offset
    drain();

    // R5: lookup port back-pressure holds a miss
    tlbLat = 2;
    tlbReqReady = 1'b0;
    reqVaddr = 48'h8000_0000_3000;
    reqWrite = 1'b1;
    reqValid = 1'b1;
    repeat (3) begin
      @(negedge clk);
      chk(reqReady == 1'b0 && tlbReqValid == 1'b1, "R5 miss waits for lookup port",
          int'(reqReady), 0);
    end
    @(posedge clk);
    #1 tlbReqReady = 1'b1;
    doReq(48'h8000_0000_3000, 1'b1);
    drain();

    // R6: base == limit disables the window
    writeCfg(2'd1, 48'h0000_0010_0FFF);
    for (int p = 0; p < 4; p++) doReq({36'h000000100 + 36'(p), 12'h010}, 1'b0);
    drain();

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule